// File: doc/BRIEF.md
# DRAM Audio Delay-Line Address Controller

This block runs a circular audio delay buffer kept in a dynamic RAM whose address pins carry the row and the column in turn. Every accepted sample strobe starts one sample period. In that period the block fetches the stored sample from the current buffer slot, then stores the new input sample in the same slot, and then moves the pointer on. The fetched value is the delayed output. It is presented on `dly_o` with a one-cycle valid pulse.

The buffer pointer has a column part and a row part. A mask on the column part sets how many column slots are used, and so sets the delay length. The row part is never masked. A row stays open across sample periods. A new row is opened only after the column counter wraps, so most periods are column-only accesses. Each column access is a read-modify-write on a single column strobe. A refresh hook adds RAS-only refresh cycles between sample periods.

Top module: `dly_dram_ctrl`

## Requirements
- R1: Each sample period reads the slot at the current pointer and then writes the new sample to the same slot. The read column is `(col + RD_OFS) & mask` with `RD_OFS` = 0 by default. The delayed output of period k is therefore the sample accepted in period k-L, where L = (mask+1)·2^ROW_W.
- R2: The address bus carries the row while `dram_ras_no` falls and the column while `dram_cas_no` is low. `dram_cas_no` is low only while `dram_ras_no` is low.
- R3: `dram_ras_no` falls only when a row is opened, and `dram_cas_no` is high at that point. For a sample period this happens only after the previous period wrapped the column counter. With mask 3, any 64 consecutive sample periods show exactly 16 row-strobe falls.
- R4: `col_mask_i` holds contiguous low ones and limits the column count to mask+1. When the column counter wraps at the masked length, it increments the row counter. The row counter wraps at 2^ROW_W.
- R5: The mask is sampled when a sample period starts. A change of `col_mask_i` during a period does not affect that period.
- R6: Each accepted sample period gives exactly one one-cycle pulse on `dly_vld_o`. `dly_o` carries the value read in that period.
- R7: A new row phase lasts ROW_CYC cycles, each column phase lasts COL_CYC cycles, and precharge lasts PRE_CYC cycles. `dram_cas_no` stays low for 2·COL_CYC cycles per period (4 by default).
- R8: A pulse on `ref_req_i` is held pending and served only between sample periods. It is served as a RAS-only cycle: an open row is closed first, then `dram_ras_no` falls with `dram_cas_no` high, on an internal refresh row counter. The cycle ends with a one-cycle `ref_ack_o`. A request raised during a sample period is acknowledged only after that period's write. A pending sample is served before a pending refresh.
- R9: A sample strobe that arrives while a previous sample period is still pending or in progress is ignored.
- R10: During reset `dram_ras_no`, `dram_cas_no` and `dram_we_no` are high, and `dly_vld_o` and `ref_ack_o` are low.
- R11: `dram_we_no` is low only while `dram_cas_no` is low. `dram_dq_o` carries the sample latched at the accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | Sample strobe, one cycle |
| smp_i | input | DATA_W | New input sample |
| col_mask_i | input | COL_W | Column mask, contiguous low ones |
| ref_req_i | input | 1 | Refresh request pulse |
| ref_ack_o | output | 1 | Refresh cycle done, one cycle |
| dly_o | output | DATA_W | Delayed sample |
| dly_vld_o | output | 1 | `dly_o` valid, one cycle |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Write data to RAM |
| dram_dq_i | input | DATA_W | Read data from RAM |

## Verification
The assertions check the strobe-ordering rules on every cycle:
- the column strobe only under an open row,
- write enable only under the column strobe,
- the row strobe never falling with the column strobe active,
- the single-cycle valid and acknowledge pulses,
- the latched mask staying still across the column phases.

Other properties only show up over many periods, so the bench's scenarios cover them against a RAM model. These are the delay length under several masks, the count of row openings per window, the column-phase length, an ignored repeat strobe, a mid-period mask change, and refresh requests raised both during and between periods.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ROW    = 3'd1,
    ST_COL_RD = 3'd2,
    ST_COL_WR = 3'd3,
    ST_PRE    = 3'd4
  } dly_st_e;
endpackage

// File: rtl/dly_ptr.sv
module dly_ptr #(
  parameter int COL_W  = 4,
  parameter int ROW_W  = 3,
  parameter int RD_OFS = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] wr_col_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             wrap_o
);
  logic [COL_W-1:0] col_q, col_m;
  logic [ROW_W-1:0] row_q;

  // bits outside a freshly shrunk mask are dropped here
  assign col_m    = col_q & mask_i;
  assign wrap_o   = (col_m == mask_i);
  assign wr_col_o = col_m;
  assign rd_col_o = (col_m + COL_W'(RD_OFS)) & mask_i;
  assign row_o    = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv_i) begin
      if (wrap_o) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_m + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dly_seq.sv
module dly_seq
  import dly_pkg::*;
#(
  parameter int ROW_CYC = 2,
  parameter int COL_CYC = 2,
  parameter int PRE_CYC = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    smp_pend_i,
  input  logic    ref_pend_i,
  input  logic    row_wrap_i,
  output dly_st_e st_o,
  output logic    row_open_o,
  output logic    ref_cyc_o,
  output logic    start_o,
  output logic    cap_o,
  output logic    adv_o,
  output logic    ref_done_o
);
  localparam int MAX_RC = (ROW_CYC > COL_CYC) ? ROW_CYC : COL_CYC;
  localparam int MAX_C  = (MAX_RC > PRE_CYC) ? MAX_RC : PRE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  dly_st_e    st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_ld;
  logic       last, ref_go, row_open_q, ref_cyc_q;

  assign last       = (cnt_q == '0);
  assign st_o       = st_q;
  assign row_open_o = row_open_q;
  assign ref_cyc_o  = ref_cyc_q;

  always_comb begin
    st_d       = st_q;
    start_o    = 1'b0;
    cap_o      = 1'b0;
    adv_o      = 1'b0;
    ref_done_o = 1'b0;
    ref_go     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (smp_pend_i) begin
          start_o = 1'b1;
          st_d    = row_open_q ? ST_COL_RD : ST_ROW;
        end else if (ref_pend_i) begin
          if (row_open_q) st_d = ST_PRE;
          else begin
            st_d   = ST_ROW;
            ref_go = 1'b1;
          end
        end
      end
      ST_ROW:    if (last) st_d = ref_cyc_q ? ST_PRE : ST_COL_RD;
      ST_COL_RD: if (last) begin
        cap_o = 1'b1;
        st_d  = ST_COL_WR;
      end
      ST_COL_WR: if (last) begin
        adv_o = 1'b1;
        st_d  = row_wrap_i ? ST_PRE : ST_IDLE;
      end
      ST_PRE: if (last) begin
        ref_done_o = ref_cyc_q;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_ROW:    cnt_ld = CNT_W'(ROW_CYC - 1);
      ST_COL_RD,
      ST_COL_WR: cnt_ld = CNT_W'(COL_CYC - 1);
      ST_PRE:    cnt_ld = CNT_W'(PRE_CYC - 1);
      default:   cnt_ld = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      row_open_q <= 1'b0;
      ref_cyc_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) cnt_q <= cnt_ld;
      else if (!last)   cnt_q <= cnt_q - 1'b1;
      if (st_q == ST_ROW && last && !ref_cyc_q) row_open_q <= 1'b1;
      else if (st_q == ST_PRE && last)          row_open_q <= 1'b0;
      if (ref_go)                               ref_cyc_q <= 1'b1;
      else if (st_q == ST_PRE && last)          ref_cyc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dly_dram_ctrl.sv
module dly_dram_ctrl
  import dly_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COL_W   = 4,
  parameter int ROW_W   = 3,
  parameter int ROW_CYC = 2,
  parameter int COL_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int RD_OFS  = 0
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      smp_stb_i,
  input  logic [DATA_W-1:0]                         smp_i,
  input  logic [COL_W-1:0]                          col_mask_i,
  input  logic                                      ref_req_i,
  output logic                                      ref_ack_o,
  output logic [DATA_W-1:0]                         dly_o,
  output logic                                      dly_vld_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic                                      dram_ras_no,
  output logic                                      dram_cas_no,
  output logic                                      dram_we_no,
  output logic [DATA_W-1:0]                         dram_dq_o,
  input  logic [DATA_W-1:0]                         dram_dq_i
);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  dly_st_e          st_q;
  logic             row_open, ref_cyc, start, cap, adv, ref_done;
  logic             smp_pend_q, ref_pend_q, vld_q;
  logic [DATA_W-1:0] smp_q, dly_q;
  logic [ROW_W-1:0] ref_row_q, ptr_row;
  logic [COL_W-1:0] mask_q, wr_col, rd_col;
  logic             row_wrap;

  dly_seq #(
    .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC), .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_pend_i (smp_pend_q),
    .ref_pend_i (ref_pend_q),
    .row_wrap_i (row_wrap),
    .st_o       (st_q),
    .row_open_o (row_open),
    .ref_cyc_o  (ref_cyc),
    .start_o    (start),
    .cap_o      (cap),
    .adv_o      (adv),
    .ref_done_o (ref_done)
  );

  dly_ptr #(
    .COL_W(COL_W), .ROW_W(ROW_W), .RD_OFS(RD_OFS)
  ) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .mask_i   (mask_q),
    .wr_col_o (wr_col),
    .rd_col_o (rd_col),
    .row_o    (ptr_row),
    .wrap_o   (row_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_pend_q <= 1'b0;
      smp_q      <= '0;
      ref_pend_q <= 1'b0;
      ref_row_q  <= '0;
      mask_q     <= '1;
      dly_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      if (smp_stb_i && !smp_pend_q) begin
        smp_pend_q <= 1'b1;
        smp_q      <= smp_i;
      end else if (adv) begin
        smp_pend_q <= 1'b0;
      end
      ref_pend_q <= ref_req_i | (ref_pend_q & ~ref_done);
      if (ref_done) ref_row_q <= ref_row_q + 1'b1;
      if (start)    mask_q    <= col_mask_i;
      vld_q <= cap;
      if (cap) dly_q <= dram_dq_i;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_ROW:    dram_addr_o = ADDR_W'(ref_cyc ? ref_row_q : ptr_row);
      ST_COL_RD: dram_addr_o = ADDR_W'(rd_col);
      ST_COL_WR: dram_addr_o = ADDR_W'(wr_col);
      default:   dram_addr_o = ADDR_W'(ptr_row);
    endcase
  end

  // row stays open in idle between column-only periods
  assign dram_ras_no = !((st_q == ST_ROW) || (st_q == ST_COL_RD) ||
                         (st_q == ST_COL_WR) || (st_q == ST_IDLE && row_open));
  assign dram_cas_no = !((st_q == ST_COL_RD) || (st_q == ST_COL_WR));
  assign dram_we_no  = !(st_q == ST_COL_WR);
  assign dram_dq_o   = smp_q;
  assign dly_o       = dly_q;
  assign dly_vld_o   = vld_q;
  assign ref_ack_o   = ref_done;
endmodule

// File: rtl/dly_chk.sv
module dly_chk
  import dly_pkg::*;
#(
  parameter int COL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             vld,
  input logic             ack,
  input dly_st_e          st,
  input logic [COL_W-1:0] mask
);
  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n |-> !ras_n);                                     // R2
  AST_ROW_OPEN_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |-> cas_n);                                // R3
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_COL_WR) |-> $stable(mask));                   // R5
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |=> !vld);                                          // R6
  AST_REF_ROW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> (cas_n && ras_n));                              // R8
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !ack);                                          // R8
  AST_WE_UNDER_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n |-> !cas_n);                                      // R11
endmodule

bind dly_dram_ctrl dly_chk #(.COL_W(COL_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ras_n  (dram_ras_no),
  .cas_n  (dram_cas_no),
  .we_n   (dram_we_no),
  .vld    (dly_vld_o),
  .ack    (ref_ack_o),
  .st     (st_q),
  .mask   (mask_q)
);

// File: tb/sim_dly_dram_ctrl.sv
`timescale 1ns/1ps
module sim_dly_dram_ctrl;
  localparam int GAP = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic [7:0] smp = '0;
  logic [3:0] mask = 4'hF;
  logic       ref_req = 1'b0;
  logic       ref_ack, vld, ras_n, cas_n, we_n;
  logic [7:0] dly, dq_o, dq_i;
  logic [3:0] addr;

  always #5 clk = ~clk;

  dly_dram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .smp_i(smp),
    .col_mask_i(mask), .ref_req_i(ref_req), .ref_ack_o(ref_ack),
    .dly_o(dly), .dly_vld_o(vld), .dram_addr_o(addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_dq_o(dq_o), .dram_dq_i(dq_i)
  );

  int errors = 0, checks = 0;
  int nsent = 0, vld_cnt = 0, ack_cnt = 0, ref_cnt = 0;
  int ras_falls = 0, we_falls = 0, cas_run = 0;
  int snap_ras = 0, snap_we = 0, phase_start = 0;
  bit ref_mid = 0, first_phase = 1, done = 0;
  logic [7:0] mem [128];
  logic [2:0] row_lat = '0;
  logic       ras_prev = 1'b1, we_prev = 1'b1;
  logic [7:0] hist [1024];
  logic [7:0] exp_v [1024];
  bit         exp_ok [1024];

  assign dq_i = mem[{row_lat, addr}];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // RAM model and output monitor
  always @(negedge clk) begin
    if (ras_prev && !ras_n) begin
      row_lat = addr[2:0];
      ras_falls++;
    end
    if (!cas_n && !we_n) mem[{row_lat, addr}] = dq_o;
    if (we_prev && !we_n) we_falls++;
    if (!cas_n) cas_run++;
    else if (cas_run != 0) begin
      chk(cas_run == 4, "R7 cas low run", cas_run, 4);
      cas_run = 0;
    end
    if (vld) begin
      if (exp_ok[vld_cnt]) chk(dly == exp_v[vld_cnt], "R1 R4 delayed data", dly, exp_v[vld_cnt]);
      vld_cnt++;
    end
    if (ref_ack) begin
      ack_cnt++;
      chk(ras_falls > snap_ras, "R8 row strobe for refresh", ras_falls, snap_ras + 1);
      if (ref_mid) chk(we_falls > snap_we, "R8 write before ack", we_falls, snap_we + 1);
    end
    ras_prev = ras_n;
    we_prev  = we_n;
  end

  task automatic send(input logic [7:0] v, input int ref_at, input bit dbl,
                      input int chg_at, input logic [3:0] chg_mask);
    int k, len;
    k   = nsent;
    len = (int'(mask) + 1) * 8;
    @(negedge clk);
    smp = v;
    stb = 1'b1;
    hist[k] = v;
    if (first_phase && k < len) begin
      exp_ok[k] = 1; exp_v[k] = 8'h00;
    end else if (k - phase_start >= len) begin
      exp_ok[k] = 1; exp_v[k] = hist[k - len];
    end
    nsent++;
    @(negedge clk);
    stb = 1'b0;
    for (int c = 1; c < GAP; c++) begin
      if (c == ref_at) begin
        snap_ras = ras_falls;
        snap_we  = we_falls;
        ref_mid  = (c < 8);
        ref_req  = 1'b1;
        ref_cnt++;
      end
      if (dbl && c == 3) begin
        smp = ~v;
        stb = 1'b1;
      end
      if (c == chg_at) mask = chg_mask;
      @(negedge clk);
      ref_req = 1'b0;
      stb = 1'b0;
    end
  endtask

  // kind: 0 plain, 1 row-strobe count, 2 repeated strobe, 3 refresh
  task automatic run_phase(input logic [3:0] m, input int n, input int kind,
                           input bit chg_last, input logic [3:0] next_m);
    int r0;
    r0 = 0;
    mask = m;
    phase_start = nsent;
    for (int i = 0; i < n; i++) begin
      int rat;
      if (kind == 1 && i == 8) r0 = ras_falls;
      if (kind == 1 && i == 72) chk(ras_falls - r0 == 16, "R3 row opens per 64", ras_falls - r0, 16);
      rat = 0;
      if (kind == 3) rat = (i % 3 == 0) ? 4 : ((i % 3 == 1) ? 14 : 0);
      send(8'((nsent * 37 + 11) & 255), rat, (kind == 2 && i == 20),
           (chg_last && i == n - 1) ? 4 : 0, next_m);
    end
    first_phase = 0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    for (int i = 0; i < 1024; i++) exp_ok[i] = 0;
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1, "R10 ras idle", ras_n, 1);
    chk(cas_n == 1'b1, "R10 cas idle", cas_n, 1);
    chk(we_n == 1'b1, "R10 we idle", we_n, 1);
    chk(vld == 1'b0 && ref_ack == 1'b0, "R10 pulses low", vld, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_phase(4'hF, 300, 0, 0, 4'h0);
    run_phase(4'h3, 100, 1, 0, 4'h0);
    // R5: mask changes mid-period in the last period of this phase
    run_phase(4'h0, 40, 2, 1, 4'h7);
    run_phase(4'h7, 150, 3, 0, 4'h0);
    repeat (100) @(negedge clk);
    chk(vld_cnt == nsent, "R6 R9 one valid per accepted strobe", vld_cnt, nsent);
    chk(ack_cnt == ref_cnt, "R8 acks", ack_cnt, ref_cnt);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", vld_cnt, nsent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule